// File: doc/BRIEF.md
# Burst QPSK Baseband I/Q Generator

This block takes a serial bit stream that is framed by a transmit-enable and turns it into two shaped baseband sample streams, in-phase and quadrature, for a burst QPSK transmitter. All bit, symbol and sample timing comes from the single master clock. A bit strobe tells the data source when its next bit is taken. Each QPSK symbol carries two bits. Bits go alternately to the I and Q rails, and the demultiplexer restarts with every burst. Each rail maps its bit to an antipodal level and feeds it to a 32-tap root-raised-cosine interpolator (roll-off 0.5, span of four symbols, eight samples per symbol). The interpolator gives signed 9-bit words that a DAC can take directly.

Outside a burst both sample outputs sit at zero. Every burst starts from a clean filter history, so nothing left over from an earlier burst shows up in a new one. At 256 kbit/s the symbol rate is 128 kbaud. The `CLK_PER_BIT` parameter sets how many master clocks make up one bit, and it must be a multiple of four so that a sample period is a whole number of clocks.

Top module: `burst_iq_gen`

## Requirements
- R1: While `rst_n` is low, `i_samp`, `q_samp` and `bit_stb` are 0 when `tx_en` is low, and both sample outputs are 0 even when `tx_en` is high.
- R2: `bit_stb` is high in the first clock cycle in which `tx_en` is high, and then every `CLK_PER_BIT` cycles while `tx_en` stays high. It is low in all other cycles.
- R3: `tx_data` is sampled only at clock edges where `bit_stb` is high. Bit 2n of a burst is the I bit of symbol n and bit 2n+1 is its Q bit, so the first bit of every burst lands on I. The value of `tx_data` at any other edge has no effect.
- R4: On each rail, bit value 0 maps to +1 and bit value 1 maps to -1.
- R5: Symbol n enters the filter at edge E = `CLK_PER_BIT`·(2n+1), counting from the first edge at which `tx_en` is high (edge 0). After edge E+1+d, for 0 ≤ d < 2·`CLK_PER_BIT`, each rail shows sample q = 8n + d/(`CLK_PER_BIT`/4) of the zero-stuffed 8x symbol stream convolved with h. Before the first symbol enters, the output is 0.
- R6: The tap values are h[0..15] = 7, 5, 0, -8, -16, -23, -26, -22, -10, 11, 40, 75, 110, 142, 167, 180, with h[31-k] = h[k].
- R7: At an edge where `tx_en` is low, both outputs become 0 and the filter history and bit-pair position are cleared. A burst that was cut short leaves no residue in the next burst.
- R8: No output sample has magnitude above 219. This peak is reached when four consecutive symbols on a rail follow the sign pattern of one filter phase.
- R9: In a burst with an odd number of bits, the source drives 0 at the final Q strobe, so the last symbol gets Q = +1 and the next burst still starts on I.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_en | input | 1 | Burst gate; high during the transmit interval |
| tx_data | input | 1 | Serial data bit, sampled when bit_stb is high |
| bit_stb | output | 1 | One-cycle pulse per bit period requesting the next bit |
| i_samp | output | 9 | Signed in-phase baseband sample |
| q_samp | output | 9 | Signed quadrature baseband sample |

## Verification
Bursts of all zeros and all ones give a constant symbol on each rail and show the raw step response on each phase. A pattern of alternating pairs is built to drive both rails to the 219 peak, which checks the tap table and the sign mapping together. Odd-length bursts followed by a fresh burst show whether the I/Q split really restarts. A burst cut off in mid-symbol, followed by another burst, shows whether any filter residue leaks across. During every burst the data line carries the opposite of the wanted bit between strobes, so sampling off the strobe would appear as a wrong sample.

// File: rtl/burst_iq_pkg.sv
`timescale 1ns/1ps
package burst_iq_pkg;

   localparam int SPS        = 8;
   localparam int SPAN       = 4;
   localparam int TAPS       = SPS * SPAN;
   localparam int COEF_W     = 9;
   localparam int PEAK_LEVEL = 219;

   typedef logic signed [COEF_W-1:0] coef_t;

   // Quantized alpha=0.5 RRC, 32 taps, scale 160; table is mirrored.
   function automatic coef_t rrc_coef(input int idx);
      int    k;
      coef_t c;
      k = (idx < TAPS/2) ? idx : (TAPS - 1 - idx);
      case (k)
         0:  c = 9'sd7;
         1:  c = 9'sd5;
         2:  c = 9'sd0;
         3:  c = -9'sd8;
         4:  c = -9'sd16;
         5:  c = -9'sd23;
         6:  c = -9'sd26;
         7:  c = -9'sd22;
         8:  c = -9'sd10;
         9:  c = 9'sd11;
         10: c = 9'sd40;
         11: c = 9'sd75;
         12: c = 9'sd110;
         13: c = 9'sd142;
         14: c = 9'sd167;
         15: c = 9'sd180;
         default: c = '0;
      endcase
      return c;
   endfunction

endpackage

// File: rtl/burst_iq_timing.sv
`timescale 1ns/1ps
module burst_iq_timing #(
   parameter int CLK_PER_BIT = 8,
   parameter int SPS         = 8
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      en,
   output logic                      bit_stb,
   output logic                      take_i,
   output logic                      commit,
   output logic [$clog2(SPS)-1:0]    ph
);
   localparam int SYM_CLKS  = 2 * CLK_PER_BIT;
   localparam int SAMP_CLKS = SYM_CLKS / SPS;
   localparam int CNT_W     = $clog2(SYM_CLKS);
   localparam int SUB_W     = (SAMP_CLKS > 1) ? $clog2(SAMP_CLKS) : 1;
   localparam int PH_W      = $clog2(SPS);

   logic [CNT_W-1:0] cnt;
   logic [SUB_W-1:0] sub;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                              cnt <= '0;
      else if (!en)                            cnt <= '0;
      else if (cnt == CNT_W'(SYM_CLKS - 1))    cnt <= '0;
      else                                     cnt <= cnt + 1'b1;
   end

   assign take_i  = en && (cnt == '0);
   assign commit  = en && (cnt == CNT_W'(CLK_PER_BIT));
   assign bit_stb = take_i || commit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sub <= '0;
         ph  <= '0;
      end else if (!en || commit) begin
         sub <= '0;
         ph  <= '0;
      end else if (sub == SUB_W'(SAMP_CLKS - 1)) begin
         sub <= '0;
         ph  <= ph + PH_W'(1);
      end else begin
         sub <= sub + 1'b1;
      end
   end

   // R2: strobes are never back to back inside a burst
   assert_stb_spacing_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (en && $past(en) && $past(rst_n) && bit_stb) |-> !$past(bit_stb));

   // R3: first edge of a burst takes an I bit
   assert_first_bit_i_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(en) |-> take_i);

endmodule

// File: rtl/burst_iq_demux.sv
`timescale 1ns/1ps
module burst_iq_demux (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   input  logic take_i,
   input  logic commit,
   input  logic din,
   output logic sym_i,
   output logic sym_q
);
   logic i_hold;
   logic have_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         i_hold <= 1'b0;
         have_i <= 1'b0;
      end else if (!en) begin
         i_hold <= 1'b0;
         have_i <= 1'b0;
      end else if (take_i) begin
         i_hold <= din;
         have_i <= 1'b1;
      end else if (commit) begin
         have_i <= 1'b0;
      end
   end

   assign sym_i = i_hold;
   assign sym_q = din;

   // R3: a symbol is never committed without its I bit from this burst
   assert_pair_order_R3: assert property (@(posedge clk) disable iff (!rst_n)
      commit |-> have_i);

endmodule

// File: rtl/burst_iq_rrc.sv
`timescale 1ns/1ps
module burst_iq_rrc
   import burst_iq_pkg::*;
#(
   parameter int SPAN_P = 4,
   parameter int SPS_P  = 8,
   parameter int OUT_W  = 9
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         clr,
   input  logic                         commit,
   input  logic                         sym_neg,
   input  logic [$clog2(SPS_P)-1:0]     ph,
   output logic signed [OUT_W-1:0]      samp
);
   localparam int ACC_W = COEF_W + $clog2(SPAN_P) + 1;
   localparam int MAXV  = 2 ** (OUT_W - 1) - 1;

   logic [SPAN_P-1:0]       valid;
   logic [SPAN_P-1:0]       neg;
   logic signed [ACC_W-1:0] acc;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid <= '0;
         neg   <= '0;
      end else if (clr) begin
         valid <= '0;
         neg   <= '0;
      end else if (commit) begin
         valid <= {valid[SPAN_P-2:0], 1'b1};
         neg   <= {neg[SPAN_P-2:0], sym_neg};
      end
   end

   always_comb begin
      acc = '0;
      for (int j = 0; j < SPAN_P; j++) begin
         if (valid[j]) begin
            if (neg[j]) acc = acc - ACC_W'(rrc_coef(int'(ph) + SPS_P * j));
            else        acc = acc + ACC_W'(rrc_coef(int'(ph) + SPS_P * j));
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   samp <= '0;
      else if (clr) samp <= '0;
      else          samp <= acc[OUT_W-1:0];
   end

   assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (acc <= ACC_W'(MAXV)) && (acc >= -ACC_W'(MAXV)));

   assert_gate_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $past(clr) |-> (samp == '0));

   assert_history_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (valid == '0));

endmodule

// File: rtl/burst_iq_gen.sv
`timescale 1ns/1ps
module burst_iq_gen
   import burst_iq_pkg::*;
#(
   parameter int CLK_PER_BIT = 8,
   parameter int OUT_W       = 9
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    tx_en,
   input  logic                    tx_data,
   output logic                    bit_stb,
   output logic signed [OUT_W-1:0] i_samp,
   output logic signed [OUT_W-1:0] q_samp
);
   localparam int PH_W  = $clog2(SPS);
   localparam int RAILS = 2;

   if ((CLK_PER_BIT % 4) != 0 || CLK_PER_BIT < 4) begin : g_bad_rate
      $error("CLK_PER_BIT must be a positive multiple of 4");
   end
   if (OUT_W < 9) begin : g_bad_width
      $error("OUT_W must hold the filter peak");
   end

   logic            take_i;
   logic            commit;
   logic [PH_W-1:0] ph;
   logic            sym_i;
   logic            sym_q;
   logic [RAILS-1:0] rail_bit;
   logic signed [OUT_W-1:0] rail_out [RAILS];

   burst_iq_timing #(.CLK_PER_BIT(CLK_PER_BIT), .SPS(SPS)) u_timing (
      .clk(clk), .rst_n(rst_n), .en(tx_en),
      .bit_stb(bit_stb), .take_i(take_i), .commit(commit), .ph(ph)
   );

   burst_iq_demux u_demux (
      .clk(clk), .rst_n(rst_n), .en(tx_en), .take_i(take_i),
      .commit(commit), .din(tx_data), .sym_i(sym_i), .sym_q(sym_q)
   );

   assign rail_bit = {sym_q, sym_i};

   for (genvar r = 0; r < RAILS; r++) begin : g_rail
      burst_iq_rrc #(.SPAN_P(SPAN), .SPS_P(SPS), .OUT_W(OUT_W)) u_rrc (
         .clk(clk), .rst_n(rst_n), .clr(!tx_en), .commit(commit),
         .sym_neg(rail_bit[r]), .ph(ph), .samp(rail_out[r])
      );
   end

   assign i_samp = rail_out[0];
   assign q_samp = rail_out[1];

   // R1: outputs idle at zero out of reset
   assert_reset_idle_R1: assert property (@(posedge clk)
      !rst_n |-> (i_samp == '0 && q_samp == '0));

endmodule

// File: tb/burst_iq_gen_tb.sv
`timescale 1ns/1ps
module burst_iq_gen_tb;
   localparam int CPB  = 8;
   localparam int SYM  = 2 * CPB;
   localparam int SAMP = SYM / 8;
   localparam int PEAK = 219;
   localparam int NVEC = 6;

   // {length in bits, pattern (bit 0 sent first)}
   localparam logic [37:0] VEC [NVEC] = '{
      {6'd8,  32'h0000_0033},
      {6'd16, 32'h0000_0000},
      {6'd16, 32'h0000_FFFF},
      {6'd13, 32'h0000_1A5B},
      {6'd20, 32'h000A_C3E5},
      {6'd1,  32'h0000_0001}
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic tx_en = 1'b0;
   logic tx_data = 1'b0;
   logic bit_stb;
   logic signed [8:0] i_samp;
   logic signed [8:0] q_samp;

   int checks = 0;
   int errors = 0;
   int peak_seen = 0;
   logic [31:0] cur_pat = '0;
   int cur_len = 0;

   always #2.5 clk = ~clk;

   burst_iq_gen u_dut (
      .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .tx_data(tx_data),
      .bit_stb(bit_stb), .i_samp(i_samp), .q_samp(q_samp)
   );

   function automatic int h(input int n);
      int k;
      int t [16] = '{7, 5, 0, -8, -16, -23, -26, -22, -10, 11, 40, 75, 110, 142, 167, 180};
      if (n < 0 || n > 31) return 0;
      k = (n < 16) ? n : 31 - n;
      return t[k];
   endfunction

   function automatic logic bit_at(input int b);
      if (b < cur_len) return cur_pat[b];
      return 1'b0;
   endfunction

   function automatic int level(input int m, input int rail);
      return bit_at(2 * m + rail) ? -1 : 1;
   endfunction

   // upsample-by-8 and convolve; e counts edges from the first enabled edge
   function automatic int model(input int e, input int rail);
      int r, n, q, s;
      if (e <= CPB) return 0;
      r = e - CPB - 1;
      n = r / SYM;
      q = 8 * n + (r % SYM) / SAMP;
      s = 0;
      for (int m = n - 3; m <= n; m++)
         if (m >= 0) s += level(m, rail) * h(q - 8 * m);
      return s;
   endfunction

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic run_burst(input logic [31:0] pat, input int len,
                            input int abort_at, input string req);
      int total;
      logic b;
      cur_pat = pat;
      cur_len = len;
      total = CPB + ((len + 1) / 2 + 4) * SYM;
      if (abort_at > 0) total = abort_at;
      for (int e = 0; e < total; e++) begin
         @(negedge clk);
         tx_en = 1'b1;
         b = bit_at(e / CPB);
         tx_data = ((e % CPB) == 0) ? b : ~b;   // off-strobe value is inverted (R3)
         #1;
         chk(bit_stb == ((e % CPB) == 0), "R2", "bit_stb", int'(bit_stb), int'((e % CPB) == 0));
         if (e > 0) begin
            chk(int'(i_samp) == model(e - 1, 0), req, "i_samp", int'(i_samp), model(e - 1, 0));
            chk(int'(q_samp) == model(e - 1, 1), req, "q_samp", int'(q_samp), model(e - 1, 1));
         end else begin
            chk(i_samp == 0 && q_samp == 0, "R7", "burst start residue", int'(i_samp), 0);
         end
         if ($signed(i_samp) > peak_seen)  peak_seen = int'(i_samp);
         if (-$signed(i_samp) > peak_seen) peak_seen = -int'(i_samp);
         if ($signed(q_samp) > peak_seen)  peak_seen = int'(q_samp);
         if (-$signed(q_samp) > peak_seen) peak_seen = -int'(q_samp);
      end
      @(negedge clk);
      tx_en = 1'b0;
      tx_data = 1'b1;
      #1;
      chk(bit_stb == 1'b0, "R7", "bit_stb gated", int'(bit_stb), 0);
      @(negedge clk);
      #1;
      chk(i_samp == 0, "R7", "i_samp gated", int'(i_samp), 0);
      chk(q_samp == 0, "R7", "q_samp gated", int'(q_samp), 0);
      @(negedge clk);
   endtask

   initial begin
      #(5.0 * 150000);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      // R1: reset state with enable low, then with enable high
      repeat (3) @(negedge clk);
      #1;
      chk(i_samp == 0 && q_samp == 0, "R1", "samples in reset", int'(i_samp), 0);
      chk(bit_stb == 1'b0, "R1", "bit_stb in reset", int'(bit_stb), 0);
      tx_en = 1'b1;
      tx_data = 1'b1;
      repeat (3) @(negedge clk);
      #1;
      chk(i_samp == 0 && q_samp == 0, "R1", "samples in reset, tx_en high", int'(q_samp), 0);
      tx_en = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // table walk: R3 R4 R5 across patterns, R9 for the odd lengths
      for (int v = 0; v < NVEC; v++) begin
         run_burst(VEC[v][31:0], int'(VEC[v][37:32]), 0,
                   ((VEC[v][32]) ? "R9" : "R5"));
      end

      // R8 and R6: the 0x33 vector drives both rails to the exact peak
      chk(peak_seen == PEAK, "R8", "peak magnitude", peak_seen, PEAK);

      // R6: single all-zero pair burst, impulse phase at the centre tap
      run_burst(32'h0, 2, 0, "R6");

      // R4: a lone 1 then 0 pair gives I=-1, Q=+1
      run_burst(32'h1, 2, 0, "R4");

      // R7: abort in mid symbol, then a fresh burst must show no residue
      run_burst(32'h0000_96F0, 16, 3 * SYM + 5, "R7");
      run_burst(32'h0000_0005, 6, 0, "R3");

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule